// File: doc/BRIEF.md
# LCD Driver Configuration Register Bank

This block keeps the configuration state of a dot-matrix LCD driver and turns it into decoded control fields for the power, bias, oscillator and display logic around it. Software reaches the same 24 bits of state through one of two views picked by a pin. The wide view offers three 8-bit registers. The narrow view offers six 4-bit registers, with each byte split into its low half then its high half. Reads return the live register contents on `rdata` in the same cycle.

The bank has a write-one initialisation bit that never holds a value. It is honoured only on a master unit and starts a busy window that lasts a set number of oscillator ticks. Bias is either derived from the duty mode or chosen explicitly. A compatibility pin pins selected bits to hard-wired values and makes writes to those bits have no effect.

Top module: `lcd_cfg_bank`

## Requirements
- R1: In the wide view (`wide_mode`=1), addresses 0..2 select byte registers A, B and C. A write stores `wdata` and a read of the same address returns it, except in register C: bit 3 is unused and reads 0, and bit 0 (the initialisation bit) reads 0.
- R2: In the narrow view (`wide_mode`=0), nibble address n (0..5) is bits [3:0] of byte register n/2 when n is even and bits [7:4] when n is odd. Writes use `wdata[3:0]` and reads return the nibble in `rdata[3:0]` with `rdata[7:4]`=0.
- R3: After reset, registers A, B and C read 00h, 02h and 00h.
- R4: Field layout. A[7:6] is `pwr_mode`, A[5:0] is `vreg_code`. B[7] is the bias-select enable, B[6:4] the bias code, B[3] is `ext_res`, B[2:0] is `rratio_code`. C[7] is `boost_fast`, C[6:4] the oscillator code, C[2] is `disp_on`, C[1] is `hi_power`, C[0] is the initialisation bit.
- R5: With the bias enable at 0, `bias_den` follows `duty_mode` 0,1,2,3 as 9, 9, 7, 5. With the enable at 1, bias codes 0..4 give 5..9 and codes 5..7 give 9.
- R6: `osc_trim` takes oscillator code 1→1, 2→2, 4→3 and 6→4. Codes 0, 3, 5 and 7 all give 0.
- R7: A write of 1 to C[0] by a master (`is_master`=1), outside compatibility mode, raises `init_busy` on the next cycle. `init_busy` stays high until INIT_TICKS `osc_tick` pulses have been seen and drops on the clock that takes the last one.
- R8: The same write with `is_master`=0 leaves `init_busy` low.
- R9: With `compat_mode`=1, register A reads DEh. B reads with bit 7 at 0 and bit 3 at 1. C reads 04h, which leaves the display on, high power off, boost slow and oscillator code 0. The decoded outputs follow these values.
- R10: In compatibility mode, writes to the fixed bits leave the stored bits unchanged, which shows once the mode is left. Writes to the other bits of B still take effect.
- R11: Writes to addresses outside the active view (3..7 wide, 6..7 narrow) change nothing, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 selects the byte view, 0 the nibble view |
| compat_mode | input | 1 | Forces fixed bits to hard-wired values |
| is_master | input | 1 | Unit is master; gates the initialisation bit |
| duty_mode | input | 2 | Duty selection used for the default bias |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| addr | input | 3 | Register address in the active view |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| osc_tick | input | 1 | One-cycle pulse per oscillator tick |
| pwr_mode | output | 2 | Power supply mode field |
| vreg_code | output | 6 | Regulator voltage code |
| rratio_code | output | 3 | Regulator resistor ratio code |
| ext_res | output | 1 | External resistor select |
| bias_den | output | 4 | Bias denominator, 5..9 |
| disp_on | output | 1 | Display enable |
| hi_power | output | 1 | High power mode |
| boost_fast | output | 1 | Booster clock select |
| osc_trim | output | 3 | Oscillator trim select, 0..4 |
| init_busy | output | 1 | Initialisation window active |

## Verification
Every byte of every register is written with walking-one, all-ones and mixed patterns in both views. Nibble-view writes are read back through the byte view, so a swapped half or a wrong register index shows up. The bias decode is swept over all duty modes, both enable states and all eight codes, and the oscillator decode over all eight codes. Together these separate the default path from the explicit path and catch prohibited codes that are mapped wrongly. The initialisation window is counted tick by tick for master and slave. Compatibility mode is entered and left around writes, so forced reads can be told apart from stored bits that were actually overwritten.

// File: rtl/lcd_cfg_pkg.sv
package lcd_cfg_pkg;

    localparam int NREG   = 3;
    localparam int REG_W  = 8;
    localparam int HALF_W = REG_W / 2;
    localparam int ADDR_W = 3;

    typedef logic [REG_W-1:0] byte_t;

    typedef enum logic [2:0] {
        TRIM_NOM = 3'd0,
        TRIM_X12 = 3'd1,
        TRIM_X09 = 3'd2,
        TRIM_X08 = 3'd3,
        TRIM_X11 = 3'd4
    } trim_e;

    typedef struct packed {
        logic [1:0] pwr;
        logic [5:0] vreg;
        logic       bse;
        logic [2:0] bs;
        logic       irs;
        logic [2:0] ir;
        logic       bf;
        logic [2:0] rf;
        logic       don;
        logic       hpm;
    } cfg_t;

    function automatic byte_t rst_val(int k);
        return (k == 1) ? 8'h02 : 8'h00;
    endfunction

    // bits that hold state; register C drops the unused bit and the strobe bit
    function automatic byte_t store_mask(int k);
        return (k == 2) ? 8'hF6 : 8'hFF;
    endfunction

    function automatic byte_t fix_mask(int k);
        case (k)
            0:       return 8'hFF;
            1:       return 8'h88;
            default: return 8'hF7;
        endcase
    endfunction

    function automatic byte_t fix_val(int k);
        case (k)
            0:       return 8'hDE;
            1:       return 8'h08;
            default: return 8'h04;
        endcase
    endfunction

    function automatic logic [3:0] bias_decode(logic bse, logic [2:0] bs, logic [1:0] duty);
        logic [3:0] d;
        if (bse) begin
            d = (bs <= 3'd4) ? (4'd5 + {1'b0, bs}) : 4'd9;
        end else begin
            case (duty)
                2'd0, 2'd1: d = 4'd9;
                2'd2:       d = 4'd7;
                default:    d = 4'd5;
            endcase
        end
        return d;
    endfunction

    function automatic trim_e trim_decode(logic [2:0] rf);
        case (rf)
            3'd1:    return TRIM_X12;
            3'd2:    return TRIM_X09;
            3'd4:    return TRIM_X08;
            3'd6:    return TRIM_X11;
            default: return TRIM_NOM;
        endcase
    endfunction

    function automatic cfg_t unpack_regs(byte_t a, byte_t b, byte_t c);
        cfg_t f;
        f.pwr  = a[7:6];
        f.vreg = a[5:0];
        f.bse  = b[7];
        f.bs   = b[6:4];
        f.irs  = b[3];
        f.ir   = b[2:0];
        f.bf   = c[7];
        f.rf   = c[6:4];
        f.don  = c[2];
        f.hpm  = c[1];
        return f;
    endfunction

endpackage

// File: rtl/lcd_cfg_view.sv
module lcd_cfg_view
    import lcd_cfg_pkg::*;
(
    input  logic              wide_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  byte_t             eff [NREG],
    output byte_t             wmask [NREG],
    output byte_t             wval [NREG],
    output logic [REG_W-1:0]  rdata
);
    localparam int NNIB = 2 * NREG;

    for (genvar k = 0; k < NREG; k++) begin : g_lane
        localparam logic [ADDR_W-1:0] BYTE_A = ADDR_W'(k);
        localparam logic [ADDR_W-1:0] LO_A   = ADDR_W'(2 * k);
        localparam logic [ADDR_W-1:0] HI_A   = ADDR_W'(2 * k + 1);
        always_comb begin
            wmask[k] = '0;
            wval[k]  = '0;
            if (wr_en) begin
                if (wide_mode) begin
                    if (addr == BYTE_A) begin
                        wmask[k] = '1;
                        wval[k]  = wdata;
                    end
                end else if (addr == LO_A) begin
                    wmask[k] = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
                    wval[k]  = {{HALF_W{1'b0}}, wdata[HALF_W-1:0]};
                end else if (addr == HI_A) begin
                    wmask[k] = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};
                    wval[k]  = {wdata[HALF_W-1:0], {HALF_W{1'b0}}};
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (wide_mode) begin
            for (int k = 0; k < NREG; k++)
                if (addr == ADDR_W'(k)) rdata = eff[k];
        end else begin
            for (int n = 0; n < NNIB; n++)
                if (addr == ADDR_W'(n))
                    rdata = {{HALF_W{1'b0}},
                             (n % 2 == 1) ? eff[n/2][REG_W-1:HALF_W] : eff[n/2][HALF_W-1:0]};
        end
    end
endmodule

// File: rtl/lcd_cfg_store.sv
module lcd_cfg_store
    import lcd_cfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  compat_mode,
    input  logic  is_master,
    input  byte_t wmask [NREG],
    input  byte_t wval [NREG],
    output byte_t eff [NREG],
    output logic  init_req
);
    localparam int STROBE_BIT = 0;
    localparam int STROBE_REG = 2;

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        byte_t q;
        byte_t m;
        always_comb begin
            m = wmask[k] & store_mask(k);
            if (compat_mode) m = m & ~fix_mask(k);
        end
        always_ff @(posedge clk) begin
            if (rst) q <= rst_val(k);
            else     q <= (q & ~m) | (wval[k] & m);
        end
        always_comb begin
            if (compat_mode) eff[k] = (q & ~fix_mask(k)) | (fix_val(k) & fix_mask(k));
            else             eff[k] = q & store_mask(k);
        end
    end

    assign init_req = wmask[STROBE_REG][STROBE_BIT] & wval[STROBE_REG][STROBE_BIT]
                    & is_master & ~compat_mode;
endmodule

// File: rtl/lcd_cfg_init_timer.sv
module lcd_cfg_init_timer #(
    parameter int INIT_TICKS = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick,
    output logic busy
);
    localparam int CNT_W = $clog2(INIT_TICKS + 1);
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(INIT_TICKS);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)                          remain <= '0;
        else if (start)                   remain <= LOAD_V;
        else if (tick && remain != '0)    remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/lcd_cfg_decode.sv
module lcd_cfg_decode
    import lcd_cfg_pkg::*;
(
    input  byte_t      eff [NREG],
    input  logic [1:0] duty_mode,
    output logic [1:0] pwr_mode,
    output logic [5:0] vreg_code,
    output logic [2:0] rratio_code,
    output logic       ext_res,
    output logic [3:0] bias_den,
    output logic       disp_on,
    output logic       hi_power,
    output logic       boost_fast,
    output logic [2:0] osc_trim
);
    cfg_t f;
    trim_e t;

    always_comb begin
        f           = unpack_regs(eff[0], eff[1], eff[2]);
        t           = trim_decode(f.rf);
        pwr_mode    = f.pwr;
        vreg_code   = f.vreg;
        rratio_code = f.ir;
        ext_res     = f.irs;
        bias_den    = bias_decode(f.bse, f.bs, duty_mode);
        disp_on     = f.don;
        hi_power    = f.hpm;
        boost_fast  = f.bf;
        osc_trim    = t;
    end
endmodule

// File: rtl/lcd_cfg_bank.sv
module lcd_cfg_bank
    import lcd_cfg_pkg::*;
#(
    parameter int INIT_TICKS = 500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wide_mode,
    input  logic       compat_mode,
    input  logic       is_master,
    input  logic [1:0] duty_mode,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       osc_tick,
    output logic [1:0] pwr_mode,
    output logic [5:0] vreg_code,
    output logic [2:0] rratio_code,
    output logic       ext_res,
    output logic [3:0] bias_den,
    output logic       disp_on,
    output logic       hi_power,
    output logic       boost_fast,
    output logic [2:0] osc_trim,
    output logic       init_busy
);
    byte_t wmask [NREG];
    byte_t wval  [NREG];
    byte_t eff   [NREG];
    logic  init_req;

    lcd_cfg_view u_view (
        .wide_mode (wide_mode),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .eff       (eff),
        .wmask     (wmask),
        .wval      (wval),
        .rdata     (rdata)
    );

    lcd_cfg_store u_store (
        .clk         (clk),
        .rst         (rst),
        .compat_mode (compat_mode),
        .is_master   (is_master),
        .wmask       (wmask),
        .wval        (wval),
        .eff         (eff),
        .init_req    (init_req)
    );

    lcd_cfg_init_timer #(.INIT_TICKS(INIT_TICKS)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (init_req),
        .tick  (osc_tick),
        .busy  (init_busy)
    );

    lcd_cfg_decode u_dec (
        .eff         (eff),
        .duty_mode   (duty_mode),
        .pwr_mode    (pwr_mode),
        .vreg_code   (vreg_code),
        .rratio_code (rratio_code),
        .ext_res     (ext_res),
        .bias_den    (bias_den),
        .disp_on     (disp_on),
        .hi_power    (hi_power),
        .boost_fast  (boost_fast),
        .osc_trim    (osc_trim)
    );
endmodule

// File: rtl/lcd_cfg_bank_chk.sv
module lcd_cfg_bank_chk (
    input logic       clk,
    input logic       rst,
    input logic       wide_mode,
    input logic       compat_mode,
    input logic       is_master,
    input logic [1:0] duty_mode,
    input logic       wr_en,
    input logic [2:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       osc_tick,
    input logic [1:0] pwr_mode,
    input logic [5:0] vreg_code,
    input logic [2:0] rratio_code,
    input logic       ext_res,
    input logic [3:0] bias_den,
    input logic       disp_on,
    input logic       hi_power,
    input logic       boost_fast,
    input logic [2:0] osc_trim,
    input logic       init_busy
);
    logic strobe_hit;
    assign strobe_hit = wr_en && wdata[0] && !compat_mode &&
                        ((wide_mode && addr == 3'd2) || (!wide_mode && addr == 3'd4));

    assert_init_start_R7: assert property (@(posedge clk) disable iff (rst)
        (strobe_hit && is_master) |=> init_busy);

    assert_init_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(init_busy) |-> $past(strobe_hit && is_master));

    assert_init_end_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(init_busy) |-> $past(osc_tick));

    assert_slave_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!is_master && !init_busy) |=> !init_busy);

    assert_bias_range_R5: assert property (@(posedge clk) disable iff (rst)
        (bias_den >= 4'd5) && (bias_den <= 4'd9));

    assert_trim_range_R6: assert property (@(posedge clk) disable iff (rst)
        osc_trim <= 3'd4);

    assert_nibble_upper_R2: assert property (@(posedge clk) disable iff (rst)
        !wide_mode |-> (rdata[7:4] == 4'h0));

    assert_compat_fields_R9: assert property (@(posedge clk) disable iff (rst)
        compat_mode |-> (pwr_mode == 2'b11 && vreg_code == 6'h1E && ext_res &&
                         disp_on && !hi_power && !boost_fast && osc_trim == 3'd0));

    assert_out_of_range_R11: assert property (@(posedge clk) disable iff (rst)
        ((wide_mode && addr > 3'd2) || (!wide_mode && addr > 3'd5)) |-> rdata == 8'h00);
endmodule

bind lcd_cfg_bank lcd_cfg_bank_chk u_chk (.*);

// File: tb/test_lcd_cfg_bank.sv
`timescale 1ns/1ps
module test_lcd_cfg_bank;
    localparam int TICKS = 5;

    logic       clk = 0;
    logic       rst = 1;
    logic       wide_mode = 1, compat_mode = 0, is_master = 1;
    logic [1:0] duty_mode = 0;
    logic       wr_en = 0;
    logic [2:0] addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       osc_tick = 0;
    logic [1:0] pwr_mode;
    logic [5:0] vreg_code;
    logic [2:0] rratio_code;
    logic       ext_res;
    logic [3:0] bias_den;
    logic       disp_on, hi_power, boost_fast;
    logic [2:0] osc_trim;
    logic       init_busy;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lcd_cfg_bank #(.INIT_TICKS(TICKS)) i_lcd_cfg_bank (.*);

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a;
        #1 d = rdata;
    endtask

    task automatic tick();
        @(negedge clk); osc_tick = 1;
        @(negedge clk); osc_tick = 0;
    endtask

    function automatic int exp_bias(logic bse, logic [2:0] bs, logic [1:0] duty);
        int tbl [4] = '{9, 9, 7, 5};
        if (!bse) return tbl[duty];
        return (bs <= 4) ? 5 + int'(bs) : 9;
    endfunction

    function automatic int exp_trim(logic [2:0] rf);
        if (rf == 1) return 1;
        if (rf == 2) return 2;
        if (rf == 4) return 3;
        if (rf == 6) return 4;
        return 0;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] pats [6] = '{8'h01, 8'h80, 8'hFF, 8'hA5, 8'h5A, 8'h3C};
        repeat (3) @(negedge clk);
        rst = 0;

        // R3 reset state
        for (int k = 0; k < 3; k++) begin
            rd(3'(k), v);
            chk("R3 reset", v, (k == 1) ? 8'h02 : 8'h00);
        end
        chk("R3 reset ratio", rratio_code, 2);
        chk("R3 reset bias", bias_den, 9);
        chk("R3 reset busy", init_busy, 0);

        // R1 / R4 byte view sweep
        for (int k = 0; k < 3; k++)
            for (int p = 0; p < 6; p++) begin
                wr(3'(k), pats[p]);
                rd(3'(k), v);
                chk("R1 byte readback", v, (k == 2) ? (pats[p] & 8'hF6) : pats[p]);
                if (k == 0) begin
                    chk("R4 pwr_mode", pwr_mode, pats[p][7:6]);
                    chk("R4 vreg_code", vreg_code, pats[p][5:0]);
                end else if (k == 1) begin
                    chk("R4 ext_res", ext_res, pats[p][3]);
                    chk("R4 rratio", rratio_code, pats[p][2:0]);
                end else begin
                    chk("R4 boost_fast", boost_fast, pats[p][7]);
                    chk("R4 disp_on", disp_on, pats[p][2]);
                    chk("R4 hi_power", hi_power, pats[p][1]);
                end
            end

        // R2 nibble view
        for (int k = 0; k < 3; k++) begin wide_mode = 1; wr(3'(k), 8'h00); end
        for (int n = 0; n < 6; n++) begin
            wide_mode = 0;
            wr(3'(n), 8'hF0 | 8'(n + 9));
            rd(3'(n), v);
            chk("R2 nibble readback", v, (n == 4) ? ((n + 9) & 4'h6) : (n + 9));
        end
        wide_mode = 1;
        rd(3'd0, v); chk("R2 nibble to byte A", v, 8'hA9);
        rd(3'd1, v); chk("R2 nibble to byte B", v, 8'hCB);
        rd(3'd2, v); chk("R2 nibble to byte C", v, 8'hE4);

        // R5 bias sweep
        for (int d = 0; d < 4; d++)
            for (int e = 0; e < 2; e++)
                for (int b = 0; b < 8; b++) begin
                    duty_mode = 2'(d);
                    wr(3'd1, {1'(e), 3'(b), 4'h0});
                    #1 chk("R5 bias", bias_den, exp_bias(1'(e), 3'(b), 2'(d)));
                end

        // R6 trim sweep
        for (int r = 0; r < 8; r++) begin
            wr(3'd2, {1'b0, 3'(r), 4'h0});
            #1 chk("R6 osc_trim", osc_trim, exp_trim(3'(r)));
        end

        // R7 initialisation as master, through the byte view
        is_master = 1;
        wr(3'd2, 8'h01);
        chk("R7 busy after strobe", init_busy, 1);
        rd(3'd2, v); chk("R7 strobe bit self-clears", v, 8'h00);
        for (int t = 0; t < TICKS - 1; t++) tick();
        chk("R7 busy before last tick", init_busy, 1);
        tick();
        chk("R7 busy after last tick", init_busy, 0);
        // through the nibble view
        wide_mode = 0;
        wr(3'd4, 8'h01);
        chk("R7 busy nibble strobe", init_busy, 1);
        for (int t = 0; t < TICKS; t++) tick();
        chk("R7 nibble window end", init_busy, 0);
        wide_mode = 1;

        // R8 slave ignores strobe
        is_master = 0;
        wr(3'd2, 8'h01);
        chk("R8 slave no busy", init_busy, 0);
        is_master = 1;

        // R9 / R10 compatibility
        wr(3'd0, 8'h12); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
        compat_mode = 1;
        rd(3'd0, v); chk("R9 compat A", v, 8'hDE);
        rd(3'd1, v); chk("R9 compat B", v, 8'h08);
        rd(3'd2, v); chk("R9 compat C", v, 8'h04);
        chk("R9 compat disp_on", disp_on, 1);
        wr(3'd0, 8'hFF);
        wr(3'd1, 8'hFF);
        rd(3'd1, v); chk("R10 compat B free bits", v, 8'h7F);
        wr(3'd2, 8'hFF);
        chk("R10 compat strobe ignored", init_busy, 0);
        compat_mode = 0;
        rd(3'd0, v); chk("R10 A unchanged", v, 8'h12);
        rd(3'd1, v); chk("R10 B fixed bits kept", v, 8'h77);
        rd(3'd2, v); chk("R10 C unchanged", v, 8'h00);

        // R11 out-of-range
        for (int a = 3; a < 8; a++) begin
            wr(3'(a), 8'hFF);
            rd(3'(a), v); chk("R11 wide out of range read", v, 0);
        end
        rd(3'd0, v); chk("R11 A untouched", v, 8'h12);
        wide_mode = 0;
        for (int a = 6; a < 8; a++) begin
            wr(3'(a), 8'hFF);
            rd(3'(a), v); chk("R11 narrow out of range read", v, 0);
        end
        wide_mode = 1;
        rd(3'd1, v); chk("R11 B untouched", v, 8'h77);
        rd(3'd2, v); chk("R11 C untouched", v, 8'h00);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule